// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address after the translation cache has missed. It accepts one request at a time. With the request come the table base and the table length values in force for the current address space. The walker cuts the address into an outer index, an inner index and a 10-bit byte offset within a 1 KB page. It first checks the outer index against the length bound. It then reads the outer table entry, and after that reads the inner table entry that holds the frame number.

Memory access goes through a read port that allows one request in flight. The walker waits for the request handshake and then for the matching response before it moves on. The response toward the requester lasts one cycle. It carries either a physical address with the four attribute bits of the final entry, or a fault flag with a two-bit cause. Servicing a fault is left to software.

Top module: `pt_walker`

## Requirements
- R1: On a successful walk, rsp_paddr holds bits 31:10 of the inner entry in bits 31:10 and the request's virtual address bits 9:0, unchanged, in bits 9:0.
- R2: The first memory read goes to address req_base + 4 * vaddr[31:20], modulo 2^32.
- R3: The second memory read goes to address {outer_entry[31:10], 10'b0} + 4 * vaddr[19:10], modulo 2^32.
- R4: If vaddr[31:20] is greater than or equal to req_len, the walker reports a fault with cause 0 and issues no memory read. A req_len of 0 therefore faults every address.
- R5: If bit 0 (valid) of the outer entry is 0, the walker reports a fault with cause 1 and issues no second read.
- R6: If bit 0 (valid) of the inner entry is 0, the walker reports a fault with cause 2.
- R7: On success, rsp_attr carries inner entry bits 3:0: bit 0 valid, bit 1 no-execute, bit 2 dirty, bit 3 referenced. On a fault, rsp_paddr and rsp_attr are 0.
- R8: mem_req_valid and mem_req_addr hold steady until mem_req_ready is seen. No new read is issued while a response is outstanding. A mem_rsp_valid that arrives with nothing outstanding is ignored.
- R9: After reset, and whenever idle, req_ready is 1 with no memory request and no response. req_ready is 0 while a walk is in progress. rsp_valid lasts exactly one cycle, after which the walker is idle again.
- R10: rsp_valid rises in the cycle after the last memory response is accepted. For a length fault, it rises in the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_base | input | 32 | Byte address of the outer table |
| req_len | input | 13 | Number of outer table entries (0 to 4096) |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Result is a page fault |
| rsp_cause | output | 2 | Fault cause: 0 length, 1 outer invalid, 2 inner invalid |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_attr | output | 4 | Final entry attributes {ref, dirty, nx, valid} |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry |

## Verification
The bench targets the length bound at the last legal outer index and one index past it, and also a length of zero. A walker that compared with the wrong inequality would either read memory for an illegal index or reject the last legal one. It sets the valid bit clear at each level in turn. A walker that tested the wrong level, or kept reading after an invalid outer entry, would show up as a wrong cause or an extra read. Memory stalls and slow responses check that the request stays steady and that no second read starts early. Stray responses in idle and a reset in the middle of a walk show whether the walker can be tricked into a false result or left stuck busy.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_RD_OUTER = 3'd1,
      ST_RD_INNER = 3'd2,
      ST_DONE     = 3'd3,
      ST_FAULT    = 3'd4
   } walk_st_e;

   typedef enum logic [1:0] {
      CAUSE_LEN   = 2'd0,
      CAUSE_OUTER = 2'd1,
      CAUSE_INNER = 2'd2
   } fault_cause_e;

   localparam int PTE_VALID_BIT = 0;
   localparam int PTE_NX_BIT    = 1;
   localparam int PTE_DIRTY_BIT = 2;
   localparam int PTE_REF_BIT   = 3;
   localparam int ATTR_W        = 4;

endpackage

// File: rtl/pt_index_split.sv
module pt_index_split #(
   parameter int VA_W   = 32,
   parameter int IDX1_W = 12,
   parameter int IDX2_W = 10,
   parameter int OFF_W  = 10
) (
   input  logic [VA_W-1:0]   vaddr,
   output logic [IDX1_W-1:0] idx_outer,
   output logic [IDX2_W-1:0] idx_inner,
   output logic [OFF_W-1:0]  offset
);
   localparam int INNER_LO = OFF_W;
   localparam int OUTER_LO = OFF_W + IDX2_W;

   if (IDX1_W + IDX2_W + OFF_W != VA_W) begin : g_bad_split
      $error("pt_index_split: index and offset widths must sum to VA_W");
   end

   assign offset    = vaddr[OFF_W-1:0];
   assign idx_inner = vaddr[INNER_LO +: IDX2_W];
   assign idx_outer = vaddr[OUTER_LO +: IDX1_W];
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
   parameter int AW          = 32,
   parameter int IDX_W       = 12,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [AW-1:0]    table_base,
   input  logic [IDX_W-1:0] index,
   output logic [AW-1:0]    entry_addr
);
   localparam int SHIFT = $clog2(ENTRY_BYTES);
   localparam int PAD   = AW - IDX_W - SHIFT;

   if (PAD < 0) begin : g_bad_width
      $error("pt_entry_addr: index too wide for address");
   end
   if ((1 << SHIFT) != ENTRY_BYTES) begin : g_bad_entry
      $error("pt_entry_addr: entry size must be a power of two");
   end

   logic [AW-1:0] scaled;
   if (SHIFT == 0) begin : g_byte
      assign scaled = {{PAD{1'b0}}, index};
   end else begin : g_scaled
      assign scaled = {{PAD{1'b0}}, index, {SHIFT{1'b0}}};
   end

   assign entry_addr = table_base + scaled;
endmodule

// File: rtl/pt_mem_port.sv
module pt_mem_port #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic [AW-1:0] addr_in,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_rsp_valid,
   output logic          rsp_take
);
   logic issued;

   assign mem_req_valid = active && !issued;
   assign mem_req_addr  = addr_in;
   assign rsp_take      = issued && mem_rsp_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issued <= 1'b0;
      end else if (rsp_take) begin
         issued <= 1'b0;
      end else if (mem_req_valid && mem_req_ready) begin
         issued <= 1'b1;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8
   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid); // R8
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walker_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int IDX1_W      = 12,
   parameter int IDX2_W      = 10,
   parameter int OFF_W       = 10,
   parameter int PTE_W       = 32,
   parameter bit LEN_CHECK_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [VA_W-1:0]     req_vaddr,
   input  logic [VA_W-1:0]     req_base,
   input  logic [IDX1_W:0]     req_len,
   output logic                rsp_valid,
   output logic                rsp_fault,
   output logic [1:0]          rsp_cause,
   output logic [VA_W-1:0]     rsp_paddr,
   output logic [ATTR_W-1:0]   rsp_attr,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic [VA_W-1:0]     mem_req_addr,
   input  logic                mem_rsp_valid,
   input  logic [PTE_W-1:0]    mem_rsp_data
);
   localparam int BASE_W      = PTE_W - OFF_W;
   localparam int ENTRY_BYTES = PTE_W / 8;
   localparam int OUTER_LO    = OFF_W + IDX2_W;

   if (PTE_W != VA_W) begin : g_bad_pte
      $error("pt_walker: entry width must equal address width");
   end
   if (OFF_W <= ATTR_W) begin : g_bad_off
      $error("pt_walker: offset must leave room for attribute bits");
   end

   walk_st_e             state_q;
   fault_cause_e         cause_q;
   logic [VA_W-1:0]      va_q;
   logic [VA_W-1:0]      ptbr_q;
   logic [BASE_W-1:0]    tbl_q;
   logic [VA_W-1:0]      paddr_q;
   logic [ATTR_W-1:0]    attr_q;

   logic [IDX1_W-1:0]    idx_outer;
   logic [IDX2_W-1:0]    idx_inner;
   logic [OFF_W-1:0]     offset;
   logic [VA_W-1:0]      outer_addr;
   logic [VA_W-1:0]      inner_addr;
   logic [VA_W-1:0]      inner_base;
   logic                 len_bad;
   logic                 port_active;
   logic                 rsp_take;
   logic                 entry_ok;
   logic                 unused_pte_bits;

   pt_index_split #(
      .VA_W(VA_W), .IDX1_W(IDX1_W), .IDX2_W(IDX2_W), .OFF_W(OFF_W)
   ) u_split (
      .vaddr(va_q), .idx_outer(idx_outer), .idx_inner(idx_inner), .offset(offset)
   );

   assign inner_base = {tbl_q, {OFF_W{1'b0}}};

   pt_entry_addr #(.AW(VA_W), .IDX_W(IDX1_W), .ENTRY_BYTES(ENTRY_BYTES)) u_outer_addr (
      .table_base(ptbr_q), .index(idx_outer), .entry_addr(outer_addr)
   );
   pt_entry_addr #(.AW(VA_W), .IDX_W(IDX2_W), .ENTRY_BYTES(ENTRY_BYTES)) u_inner_addr (
      .table_base(inner_base), .index(idx_inner), .entry_addr(inner_addr)
   );

   if (LEN_CHECK_EN) begin : g_len_check
      assign len_bad = {1'b0, req_vaddr[OUTER_LO +: IDX1_W]} >= req_len;
      AST_LEN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid && req_ready && ({1'b0, req_vaddr[OUTER_LO +: IDX1_W]} >= req_len)
         |=> rsp_valid && rsp_fault && rsp_cause == 2'd0 && !mem_req_valid); // R4
   end else begin : g_no_len_check
      assign len_bad = 1'b0;
   end

   assign port_active = (state_q == ST_RD_OUTER) || (state_q == ST_RD_INNER);

   pt_mem_port #(.AW(VA_W)) u_port (
      .clk(clk), .rst_n(rst_n), .active(port_active),
      .addr_in((state_q == ST_RD_INNER) ? inner_addr : outer_addr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .rsp_take(rsp_take)
   );

   assign entry_ok        = mem_rsp_data[PTE_VALID_BIT];
   assign unused_pte_bits = ^mem_rsp_data[OFF_W-1:ATTR_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cause_q <= CAUSE_LEN;
         va_q    <= '0;
         ptbr_q  <= '0;
         tbl_q   <= '0;
         paddr_q <= '0;
         attr_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_vaddr;
                  ptbr_q  <= req_base;
                  paddr_q <= '0;
                  attr_q  <= '0;
                  if (len_bad) begin
                     cause_q <= CAUSE_LEN;
                     state_q <= ST_FAULT;
                  end else begin
                     state_q <= ST_RD_OUTER;
                  end
               end
            end
            ST_RD_OUTER: begin
               if (rsp_take) begin
                  if (!entry_ok) begin
                     cause_q <= CAUSE_OUTER;
                     state_q <= ST_FAULT;
                  end else begin
                     tbl_q   <= mem_rsp_data[PTE_W-1:OFF_W];
                     state_q <= ST_RD_INNER;
                  end
               end
            end
            ST_RD_INNER: begin
               if (rsp_take) begin
                  if (!entry_ok) begin
                     cause_q <= CAUSE_INNER;
                     state_q <= ST_FAULT;
                  end else begin
                     paddr_q <= {mem_rsp_data[PTE_W-1:OFF_W], offset};
                     attr_q  <= mem_rsp_data[ATTR_W-1:0];
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_DONE, ST_FAULT: state_q <= ST_IDLE;
            default:           state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign rsp_valid = (state_q == ST_DONE) || (state_q == ST_FAULT);
   assign rsp_fault = (state_q == ST_FAULT);
   assign rsp_cause = cause_q;
   assign rsp_paddr = paddr_q;
   assign rsp_attr  = attr_q;

   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid && req_ready); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !rsp_valid && !mem_req_valid); // R9
   AST_DONE_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> $past(mem_rsp_valid)); // R10
   AST_OUTER_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_RD_OUTER && rsp_take && !mem_rsp_data[PTE_VALID_BIT]
      |=> rsp_fault && rsp_cause == 2'd1); // R5
   AST_INNER_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_RD_INNER && rsp_take && !mem_rsp_data[PTE_VALID_BIT]
      |=> rsp_fault && rsp_cause == 2'd2); // R6
   AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_paddr == '0 && rsp_attr == '0); // R7
   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]); // R1
endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [31:0] req_base = '0;
   logic [12:0] req_len = '0;
   logic        rsp_valid, rsp_fault;
   logic [1:0]  rsp_cause;
   logic [31:0] rsp_paddr;
   logic [3:0]  rsp_attr;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   pt_walker u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_base(req_base), .req_len(req_len),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
      .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data)
   );

   typedef struct packed {
      logic [31:0] vaddr;
      logic [31:0] base;
      logic [12:0] len;
      logic [31:0] oute;
      logic [31:0] inne;
      logic [3:0]  stall;
      logic [3:0]  lat;
      logic        fault;
      logic [1:0]  cause;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{32'h0040_2C15, 32'h0001_0000, 13'd16,   32'h0002_0401, 32'h1234_5C0D, 4'd0, 4'd0, 1'b0, 2'd0},
      '{32'h00FF_FFFF, 32'h0000_8000, 13'd16,   32'h0007_FC01, 32'hABCD_E40F, 4'd2, 4'd3, 1'b0, 2'd0},
      '{32'h0100_0000, 32'h0000_8000, 13'd16,   32'h0007_FC01, 32'hABCD_E40F, 4'd0, 4'd0, 1'b1, 2'd0},
      '{32'h0030_1234, 32'h0002_0000, 13'd64,   32'h0003_0000, 32'h7777_7C01, 4'd1, 4'd1, 1'b1, 2'd1},
      '{32'h0005_0BCD, 32'h0004_0000, 13'd64,   32'h0009_0001, 32'h5555_540E, 4'd0, 4'd2, 1'b1, 2'd2},
      '{32'hFFF0_03A5, 32'h4000_0000, 13'd4096, 32'h0010_0C09, 32'h0000_0403, 4'd3, 4'd0, 1'b0, 2'd0},
      '{32'h0000_0000, 32'h0001_0000, 13'd0,    32'h0002_0401, 32'h1234_5C0D, 4'd0, 4'd0, 1'b1, 2'd0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      logic [31:0] eo, ei;
      int exp_reads, reads, stall, lat;
      logic pend, prev_act, this_act, got, seen;
      logic [31:0] held;
      eo = v.base + {18'b0, v.vaddr[31:20], 2'b00};
      ei = {v.oute[31:10], 10'b0} + {20'b0, v.vaddr[19:10], 2'b00};
      exp_reads = !v.fault ? 2 : (v.cause == 2'd0 ? 0 : (v.cause == 2'd1 ? 1 : 2));
      reads = 0; stall = v.stall; lat = 0; pend = 0; got = 0; seen = 0; held = '0;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = v.vaddr; req_base = v.base; req_len = v.len;
      @(negedge clk);
      req_valid = 1'b0; req_vaddr = '0;
      chk("R9 busy ready", {31'b0, req_ready}, 32'd0);
      prev_act = 1'b1;
      for (int it = 0; it < 60 && !got; it++) begin
         if (it > 0) @(negedge clk);
         this_act = 1'b0;
         mem_req_ready = 1'b0;
         mem_rsp_valid = 1'b0;
         if (rsp_valid) begin
            got = 1'b1;
            chk("R10 latency", {31'b0, prev_act}, 32'd1);
            chk("R4/R5/R6 fault flag", {31'b0, rsp_fault}, {31'b0, v.fault});
            if (v.fault) begin
               chk("R4/R5/R6 cause", {30'b0, rsp_cause}, {30'b0, v.cause});
               chk("R7 fault paddr", rsp_paddr, 32'd0);
               chk("R7 fault attr", {28'b0, rsp_attr}, 32'd0);
            end else begin
               chk("R1 paddr", rsp_paddr, {v.inne[31:10], v.vaddr[9:0]});
               chk("R7 attr", {28'b0, rsp_attr}, {28'b0, v.inne[3:0]});
            end
         end else if (pend) begin
            chk("R8 no second read", {31'b0, mem_req_valid}, 32'd0);
            if (lat == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = (reads == 1) ? v.oute : v.inne;
               pend = 1'b0;
               this_act = 1'b1;
            end else begin
               lat--;
            end
         end else if (mem_req_valid) begin
            if (!seen) begin
               held = mem_req_addr; seen = 1'b1;
            end else begin
               chk("R8 addr held", mem_req_addr, held);
            end
            if (stall > 0) begin
               stall--;
            end else begin
               mem_req_ready = 1'b1;
               reads++;
               if (reads == 1) chk("R2 outer addr", mem_req_addr, eo);
               else            chk("R3 inner addr", mem_req_addr, ei);
               pend = 1'b1; lat = v.lat; seen = 1'b0; stall = v.stall;
            end
         end
         prev_act = this_act;
      end
      if (!got) chk("R10 response seen", 32'd0, 32'd1);
      chk("R4/R5 read count", reads, exp_reads);
      @(negedge clk);
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
      chk("R9 pulse ends", {30'b0, rsp_valid, req_ready}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset ready", {29'b0, req_ready, mem_req_valid, rsp_valid}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 idle after reset", {29'b0, req_ready, mem_req_valid, rsp_valid}, 32'h4);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R8: stray response while idle is ignored
      @(negedge clk);
      mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_FFFF;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R8 stray rsp ignored", {30'b0, rsp_valid, req_ready}, 32'd1);
      @(negedge clk);
      chk("R8 stray rsp still idle", {30'b0, rsp_valid, mem_req_valid}, 32'd0);

      // R9: reset in the middle of a walk
      req_valid = 1'b1; req_vaddr = 32'h0040_0000; req_base = 32'h0001_0000; req_len = 13'd16;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 walk started", {31'b0, mem_req_valid}, 32'd1);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 reset mid-walk", {29'b0, req_ready, mem_req_valid, rsp_valid}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: last legal index after reset still reaches memory
      run_vec(VECS[1]);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule